// File: doc/BRIEF.md
# DDR Input Capture and Resynchronizer

This block is the input-side register stage for a group of data pins, placed before the pins reach core logic. It has two capture modes. In single-data-rate mode each pin is registered once per system clock. In double-data-rate mode each pin is sampled on both edges of a source-synchronous strobe. The two resulting words are aligned to the falling strobe edge and then moved into the system-clock domain as one combined word. A purely combinational copy of the pins is also available for logic that needs the raw value.

The crossing from the strobe domain uses two sync register banks. One bank loads on the rising system-clock edge and the other on the falling edge. A polarity input picks one of the two banks through a static multiplexer. A final register on the rising system-clock edge sits after the multiplexer, so the chosen bank never drives the core directly.

A synchronous, active-high reset clears every output register. A clock enable freezes every system-clock register. The strobe-side capture registers keep sampling regardless of the enable.

Top module: `ddr_in_capture`

## Requirements
- R1: `bypassOut` always equals `dataIn` combinationally, with no register in the path, in every mode and during reset.
- R2: With `rst` high at a rising `clk` edge, `sdrOut` and `ddrOut` are zero after that edge.
- R3: With `ddrMode` = 0 and `ce` = 1, `sdrOut` takes the value of `dataIn` at each rising `clk` edge.
- R4: In DDR mode, the word sampled at a rising strobe edge and the word sampled at the following falling strobe edge are delivered together. The rising-edge word is in `ddrOut[2*WIDTH-1:WIDTH]` and the falling-edge word is in `ddrOut[WIDTH-1:0]`.
- R5: With `syncPol` = 0 (rising-edge sync bank) and a strobe phase-aligned with `clk`, the pair whose rising sample was taken at `clk` rising edge k is on `ddrOut` after rising edge k+2.
- R6: With `syncPol` = 1 (falling-edge sync bank) and the same strobe, the latency is the same as in R5.
- R7: Changing `syncPol` between cycles while in DDR mode leaves the `ddrOut` sequence intact: no pair is lost, repeated or corrupted.
- R8: While `ce` = 0, `sdrOut` and `ddrOut` hold their values.
- R9: In DDR mode (`ddrMode` = 1) `sdrOut` holds its value. In SDR mode (`ddrMode` = 0) `ddrOut` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| dqs | input | 1 | Data strobe from the source |
| rst | input | 1 | Synchronous active-high reset (system clock) |
| ce | input | 1 | Clock enable for the SDR and sync registers |
| ddrMode | input | 1 | 1 = double-data-rate capture, 0 = single-data-rate |
| syncPol | input | 1 | 1 = falling-edge sync bank, 0 = rising-edge sync bank |
| dataIn | input | WIDTH | Pin values |
| bypassOut | output | WIDTH | Combinational copy of the pins |
| sdrOut | output | WIDTH | Single-data-rate registered word |
| ddrOut | output | 2*WIDTH | Retimed {rise word, fall word} |

## Verification
The assertions check the following on every cycle:
- a load strobe moves the SDR register;
- an idle or disabled strobe freezes the SDR and DDR outputs;
- the outputs are zero on the cycle that reset is released.

Some properties depend on the data timing across both clocks, so only the bench scenarios can show them:
- the rise and fall words are paired in the correct order;
- the fixed two-cycle latency holds for both sync polarities;
- switching polarity in the middle of a stream loses or repeats no pair.

// File: rtl/ddr_in_pkg.sv
`timescale 1ns/1ps
package ddr_in_pkg;
  // Strobes from the control module to the datapath
  typedef struct packed {
    logic clear;     // synchronous clear of all output registers
    logic sdrLoad;   // SDR register loads this cycle
    logic syncLoad;  // sync banks and output stage load this cycle
    logic useNeg;    // select the falling-edge sync bank
  } capCtrl_t;
endpackage

// File: rtl/ddr_in_ctrl.sv
`timescale 1ns/1ps
module ddr_in_ctrl (
  input  logic                 rst,
  input  logic                 ce,
  input  logic                 ddrMode,
  input  logic                 syncPol,
  output ddr_in_pkg::capCtrl_t ctl
);
  always_comb begin
    ctl.clear    = rst;
    ctl.sdrLoad  = ce & ~ddrMode;
    ctl.syncLoad = ce & ddrMode;
    ctl.useNeg   = syncPol;
  end
endmodule

// File: rtl/ddr_in_syncbank.sv
`timescale 1ns/1ps
module ddr_in_syncbank #(
  parameter int W        = 2,
  parameter bit NEG_EDGE = 1'b0
) (
  input  logic         clk,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (NEG_EDGE) begin : g_neg
      always_ff @(negedge clk) begin
        if (clear)     q <= '0;
        else if (load) q <= d;
      end
    end else begin : g_pos
      always_ff @(posedge clk) begin
        if (clear)     q <= '0;
        else if (load) q <= d;
      end
    end
  endgenerate
endmodule

// File: rtl/ddr_in_dpath.sv
`timescale 1ns/1ps
module ddr_in_dpath #(
  parameter int WIDTH = 4
) (
  input  logic                 clk,
  input  logic                 dqs,
  input  ddr_in_pkg::capCtrl_t ctl,
  input  logic [WIDTH-1:0]     dataIn,
  output logic [WIDTH-1:0]     bypassOut,
  output logic [WIDTH-1:0]     sdrOut,
  output logic [2*WIDTH-1:0]   ddrOut
);
  localparam int PAIR_W = 2 * WIDTH;
  localparam int NBANK  = 2;

  // Strobe-domain capture: these registers run freely and are not reset.
  logic [WIDTH-1:0] riseCap;
  logic [WIDTH-1:0] riseHold;
  logic [WIDTH-1:0] fallCap;

  always_ff @(posedge dqs) riseCap <= dataIn;

  // Re-time the rise word to the falling strobe edge so both words change together
  always_ff @(negedge dqs) begin
    riseHold <= riseCap;
    fallCap  <= dataIn;
  end

  logic [PAIR_W-1:0] pairWord;
  assign pairWord = {riseHold, fallCap};

  // Two sync banks: index 0 on the rising clk edge, index 1 on the falling clk edge
  logic [PAIR_W-1:0] bankQ [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    ddr_in_syncbank #(
      .W        (PAIR_W),
      .NEG_EDGE (b == 1)
    ) i_bank (
      .clk   (clk),
      .clear (ctl.clear),
      .load  (ctl.syncLoad),
      .d     (pairWord),
      .q     (bankQ[b])
    );
  end

  logic [PAIR_W-1:0] bankSel;
  assign bankSel = ctl.useNeg ? bankQ[1] : bankQ[0];

  // Output stage in the rising-edge system domain
  always_ff @(posedge clk) begin
    if (ctl.clear)         ddrOut <= '0;
    else if (ctl.syncLoad) ddrOut <= bankSel;
  end

  always_ff @(posedge clk) begin
    if (ctl.clear)        sdrOut <= '0;
    else if (ctl.sdrLoad) sdrOut <= dataIn;
  end

  assign bypassOut = dataIn;

  // R3: a load strobe moves the pin word into the SDR register
  a_r3_sdr_capture: assert property (@(posedge clk) disable iff (ctl.clear)
    ctl.sdrLoad |=> sdrOut == $past(dataIn));

  // R8 and R9: without its load strobe, each output holds its value
  a_r9_sdr_idle: assert property (@(posedge clk) disable iff (ctl.clear)
    !ctl.sdrLoad |=> $stable(sdrOut));

  a_r9_ddr_idle: assert property (@(posedge clk) disable iff (ctl.clear)
    !ctl.syncLoad |=> $stable(ddrOut));
endmodule

// File: rtl/ddr_in_capture.sv
`timescale 1ns/1ps
module ddr_in_capture #(
  parameter int WIDTH = 4
) (
  input  logic               clk,
  input  logic               dqs,
  input  logic               rst,
  input  logic               ce,
  input  logic               ddrMode,
  input  logic               syncPol,
  input  logic [WIDTH-1:0]   dataIn,
  output logic [WIDTH-1:0]   bypassOut,
  output logic [WIDTH-1:0]   sdrOut,
  output logic [2*WIDTH-1:0] ddrOut
);
  ddr_in_pkg::capCtrl_t ctl;

  ddr_in_ctrl i_ctrl (
    .rst     (rst),
    .ce      (ce),
    .ddrMode (ddrMode),
    .syncPol (syncPol),
    .ctl     (ctl)
  );

  ddr_in_dpath #(.WIDTH(WIDTH)) i_dpath (
    .clk       (clk),
    .dqs       (dqs),
    .ctl       (ctl),
    .dataIn    (dataIn),
    .bypassOut (bypassOut),
    .sdrOut    (sdrOut),
    .ddrOut    (ddrOut)
  );

  // R2: on the cycle reset is released, both output registers read zero
  a_r2_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (sdrOut == '0) && (ddrOut == '0));

  // R8: a deasserted enable freezes both registered outputs
  a_r8_ce_hold: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(sdrOut) && $stable(ddrOut));
endmodule

// File: tb/test_ddr_in_capture.sv
`timescale 1ns/1ps
module test_ddr_in_capture;
  localparam int W = 4;

  logic clk = 1'b0;
  logic dqs;
  logic rst = 1'b1;
  logic ce = 1'b1;
  logic ddrMode = 1'b1;
  logic syncPol = 1'b0;
  logic [W-1:0]   dataIn = '0;
  logic [W-1:0]   bypassOut;
  logic [W-1:0]   sdrOut;
  logic [2*W-1:0] ddrOut;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  // History of pairs sent, one and two cycles back
  logic [W-1:0] h1r = '0, h1f = '0, h2r = '0, h2f = '0;
  logic [W-1:0]   lastSdr = '0;
  logic [2*W-1:0] lastDdr = '0;
  int settle = 3;
  logic polPrev1 = 1'b0, polPrev2 = 1'b0;

  always #5 clk = ~clk;     // 100 MHz
  assign dqs = clk;         // strobe phase-aligned with the system clock

  ddr_in_capture #(.WIDTH(W)) i_ddr_in_capture (
    .clk(clk), .dqs(dqs), .rst(rst), .ce(ce), .ddrMode(ddrMode),
    .syncPol(syncPol), .dataIn(dataIn), .bypassOut(bypassOut),
    .sdrOut(sdrOut), .ddrOut(ddrOut)
  );

  function automatic logic [2*W-1:0] expPair(input logic [W-1:0] r, f);
    return {r, f};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One system cycle. Entered 3 ns before a rising edge.
  task automatic step(input logic [W-1:0] r, input logic [W-1:0] f,
                      input logic ceV, input logic modeV,
                      input logic polV, input logic rstV);
    dataIn = r; ce = ceV; ddrMode = modeV; syncPol = polV; rst = rstV;
    #5;  // 2 ns after the rising edge
    chk("R1 bypass", bypassOut, r);
    if (rstV) begin
      chk("R2 sdr reset", sdrOut, '0);
      chk("R2 ddr reset", ddrOut, '0);
      settle = 3;
    end else if (!ceV) begin
      chk("R8 sdr hold", sdrOut, lastSdr);
      chk("R8 ddr hold", ddrOut, lastDdr);
      settle = 3;
    end else if (!modeV) begin
      chk("R3 sdr capture", sdrOut, r);
      chk("R9 ddr idle in sdr", ddrOut, lastDdr);
      settle = 3;
    end else begin
      chk("R9 sdr idle in ddr", sdrOut, lastSdr);
      if (settle > 0) settle--;
      else if (polPrev1 != polV || polPrev2 != polPrev1)
        chk("R7 polarity switch", ddrOut, expPair(h2r, h2f));
      else if (polV)
        chk("R6 neg bank pair", ddrOut, expPair(h2r, h2f));
      else
        chk("R5 pos bank pair", ddrOut, expPair(h2r, h2f));
    end
    lastSdr = sdrOut;
    lastDdr = ddrOut;
    dataIn = f;
    #5;
    h2r = h1r; h2f = h1f; h1r = r; h1f = f;
    polPrev2 = polPrev1; polPrev1 = polV;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    #2;  // 3 ns before the first rising edge at 5 ns
    for (int i = 0; i < 3; i++) step(4'h3, 4'hC, 1'b1, 1'b1, 1'b0, 1'b1);

    // DDR, rising-edge bank
    for (int i = 0; i < 30; i++) step(W'($urandom), W'($urandom), 1'b1, 1'b1, 1'b0, 1'b0);

    // R4: directed pair order check
    step('1, '0, 1'b1, 1'b1, 1'b0, 1'b0);
    step(4'h5, 4'hA, 1'b1, 1'b1, 1'b0, 1'b0);
    dataIn = 4'h0; #5;
    chk("R4 rise word high", ddrOut, {4'hF, 4'h0});
    lastDdr = ddrOut; lastSdr = sdrOut;
    #5;
    h2r = h1r; h2f = h1f; h1r = 4'h0; h1f = 4'h0;
    polPrev2 = polPrev1;
    step(4'h6, 4'h9, 1'b1, 1'b1, 1'b0, 1'b0);

    // Switch to the falling-edge bank mid-stream
    for (int i = 0; i < 30; i++) step(W'($urandom), W'($urandom), 1'b1, 1'b1, 1'b1, 1'b0);

    // Enable low window
    for (int i = 0; i < 5; i++) step(W'($urandom), W'($urandom), 1'b0, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 6; i++) step(W'($urandom), W'($urandom), 1'b1, 1'b1, 1'b1, 1'b0);

    // SDR mode
    for (int i = 0; i < 20; i++) step(W'($urandom), W'($urandom), 1'b1, 1'b0, 1'b0, 1'b0);
    step(4'hF, 4'h0, 1'b1, 1'b0, 1'b0, 1'b0);
    step(4'h0, 4'hF, 1'b1, 1'b0, 1'b0, 1'b0);

    // Reset in the middle of the run
    step(4'h7, 4'h8, 1'b1, 1'b1, 1'b0, 1'b1);

    // Random mix
    for (int i = 0; i < 150; i++) begin
      logic ceR, modeR, polR, rstR;
      ceR   = ($urandom % 8) != 0;
      modeR = ($urandom % 6) != 0;
      polR  = ($urandom % 5) == 0 ? ~syncPol : syncPol;
      rstR  = ($urandom % 40) == 0;
      step(W'($urandom), W'($urandom), ceR, modeR, polR, rstR);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule